// File: doc/BRIEF.md
# Maskable Attention Interrupt Register Set

This block gathers twelve attention request lines from the surrounding logic into a sticky status register. It gates that register with a twelve-bit mask and raises one interrupt request line when an overall enable bit is set. Software reaches the block through a small register-bus slave port. The port has a word address, write and read strobes, 16-bit data and two byte enables. Status and mask each have dedicated addresses for their update styles, so software never needs a read-modify-write to change a single bit.

The interrupt handler sees the request through an acknowledge handshake. While the acknowledge input is high, the block presents an 8-bit software-programmed vector. The acknowledge also withdraws the request. The request stays withdrawn until a further attention event arrives on a source whose mask bit is set, so one event produces one interrupt.

An asynchronous active-low reset is released synchronously inside the block. Reset returns every register to zero.

Top module: `attn_irq_regs`

## Requirements
- R1: A rising edge on `src_i[n]` sets status bit n at the next clock edge. A source held high does not set the bit again after software has cleared it.
- R2: A status bit stays set until software clears it. If a source edge and a clear of the same bit occur in the same cycle, the bit ends up set.
- R3: Writing address 0x0 clears each status bit whose data bit is one, and leaves the others alone. Any write to address 0x1 clears the whole status register. A read of 0x0 returns status in bits 11:0.
- R4: Writing address 0x2 loads the mask, and a read of 0x2 returns it in bits 11:0. Byte enable bit 0 governs mask bits 7:0 and byte enable bit 1 governs mask bits 11:8. Bits of a disabled lane keep their value.
- R5: Any write to 0x3 clears the whole mask. Writing 0x4 sets each mask bit whose data bit is one. Writing 0x5 clears each mask bit whose data bit is one.
- R6: Address 0x6 bit 0 is the overall enable, readable and writable through byte lane 0. `irq_o` is high exactly when the enable is set, at least one status bit is set with its mask bit set, and no acknowledge is outstanding.
- R7: Address 0x7 holds the 8-bit vector in bits 7:0, written through byte lane 0 and readable back. `iack_vec_o` shows the vector while `iack_i` is high and is zero otherwise.
- R8: An `iack_i` cycle while `irq_o` is high drops `irq_o` from the next cycle on. The request returns only after a rising edge on a source whose mask bit is set. Mask writes and edges on unmasked sources do not bring it back.
- R9: After reset, status, mask, enable and vector are zero and `irq_o` is low. Reads of unmapped addresses and reads without `rd_i` return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 12 | Attention request lines, edge sensitive |
| addr_i | input | 4 | Register word address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; read data is valid in the same cycle |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables for the write data |
| rdata_o | output | 16 | Read data, zero when no read is active |
| iack_i | input | 1 | Interrupt acknowledge |
| iack_vec_o | output | 8 | Vector presented during acknowledge |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench lines up a source edge and a selective clear of the same bit in one cycle. A design that lets the clear win would lose that event, and the status read would return zero. It holds a source high across a clear, where a level-sensitive design would set the bit again at once. It also drives partial byte-enable writes to the mask and vector, which a design ignoring the lanes would corrupt. After an acknowledge, the bench tries an unmasked source edge and then a mask write before the real re-arm. A design that re-arms on those would raise the request again too early, and one that never re-arms would leave the line low for good.

// File: rtl/attn_pkg.sv
package attn_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT         = 4'h0,
    REG_STAT_CLR_ALL = 4'h1,
    REG_MASK         = 4'h2,
    REG_MASK_CLR_ALL = 4'h3,
    REG_MASK_SET_SEL = 4'h4,
    REG_MASK_CLR_SEL = 4'h5,
    REG_CTRL         = 4'h6,
    REG_VEC          = 4'h7
  } reg_addr_e;
endpackage

// File: rtl/attn_rst_sync.sv
module attn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/attn_status.sv
module attn_status #(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_all_i,
  input  logic [NUM_SRC-1:0] clr_sel_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] set_evt_o
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] clr_vec;
  logic               status_en;

  always_comb begin
    set_evt_o = src_i & ~src_q;
    clr_vec   = clr_sel_i | {NUM_SRC{clr_all_i}};
    status_en = (|set_evt_o) | (|clr_vec);
    // the set term is applied last so a same-cycle event survives the clear
    status_d  = (status_q & ~clr_vec) | set_evt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      status_q <= '0;
    end else begin
      src_q <= src_i;
      if (status_en) status_q <= status_d;
    end
  end

  assign status_o = status_q;

  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt_o) |=> ((status_q & $past(set_evt_o)) == $past(set_evt_o)));

  a_r1_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(set_evt_o)) == '0));

  a_r2_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_evt_o & clr_vec)) |=> ((status_q & $past(set_evt_o & clr_vec)) == $past(set_evt_o & clr_vec)));

  a_r3_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_sel_i) |=> ((status_q & $past(clr_sel_i) & ~$past(set_evt_o)) == '0));

  a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> ((status_q & ~$past(set_evt_o)) == '0));
endmodule

// File: rtl/attn_mask.sv
module attn_mask #(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_full_i,
  input  logic [NUM_SRC-1:0] full_wmask_i,
  input  logic [NUM_SRC-1:0] full_data_i,
  input  logic               clr_all_i,
  input  logic [NUM_SRC-1:0] set_sel_i,
  input  logic [NUM_SRC-1:0] clr_sel_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               mask_en;

  always_comb begin
    mask_en = wr_full_i | clr_all_i | (|set_sel_i) | (|clr_sel_i);
    mask_d  = mask_q;
    if (wr_full_i) mask_d = (mask_q & ~full_wmask_i) | (full_data_i & full_wmask_i);
    if (clr_all_i) mask_d = '0;
    mask_d = (mask_d | set_sel_i) & ~clr_sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r4_full_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full_i |=> ((mask_q & $past(full_wmask_i)) == ($past(full_data_i) & $past(full_wmask_i))));

  a_r4_full_write_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full_i |=> (((mask_q ^ $past(mask_q)) & ~$past(full_wmask_i)) == '0));

  a_r5_sel_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_sel_i) |=> ((mask_q & $past(set_sel_i)) == $past(set_sel_i)));

  a_r5_sel_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_sel_i) |=> ((mask_q & $past(clr_sel_i)) == '0));

  a_r5_clr_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (mask_q == '0));
endmodule

// File: rtl/attn_irq_ctrl.sv
module attn_irq_ctrl #(
  parameter int NUM_SRC = 12,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr_i,
  input  logic               en_data_i,
  input  logic               vec_wr_i,
  input  logic [VEC_W-1:0]   vec_wmask_i,
  input  logic [VEC_W-1:0]   vec_data_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] set_evt_i,
  input  logic               iack_i,
  output logic               en_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [VEC_W-1:0]   iack_vec_o,
  output logic               irq_o
);
  logic               en_q, en_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               acked_q, acked_d;
  logic               pending, rearm, ack_take;

  always_comb begin
    pending  = |(status_i & mask_i);
    rearm    = |(set_evt_i & mask_i);
    irq_o    = en_q & pending & ~acked_q;
    ack_take = iack_i & irq_o;

    en_d  = en_wr_i ? en_data_i : en_q;
    vec_d = vec_wr_i ? ((vec_q & ~vec_wmask_i) | (vec_data_i & vec_wmask_i)) : vec_q;

    acked_d = acked_q;
    if (ack_take) acked_d = 1'b1;
    if (rearm)    acked_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      vec_q   <= '0;
      acked_q <= 1'b0;
    end else begin
      if (en_wr_i)          en_q    <= en_d;
      if (vec_wr_i)         vec_q   <= vec_d;
      if (ack_take | rearm) acked_q <= acked_d;
    end
  end

  assign en_o       = en_q;
  assign vec_o      = vec_q;
  assign iack_vec_o = iack_i ? vec_q : '0;

  a_r6_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_q == $past(en_data_i)));

  a_r7_vec_write: assert property (@(posedge clk) disable iff (!rst_n)
    vec_wr_i |=> ((vec_q & $past(vec_wmask_i)) == ($past(vec_data_i) & $past(vec_wmask_i))));

  a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && irq_o && !rearm) |=> !irq_o);

  a_r8_rearm_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acked_q) && !$past(rearm)) |-> !irq_o);
endmodule

// File: rtl/attn_irq_regs.sv
module attn_irq_regs
  import attn_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int DATA_W  = 16,
  parameter int VEC_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                iack_i,
  output logic [VEC_W-1:0]    iack_vec_o,
  output logic                irq_o
);
  localparam int NUM_LANES = DATA_W / 8;

  logic               rst_sync_n;
  logic [NUM_SRC-1:0] src_lane_m, wsrc;
  logic [VEC_W-1:0]   vec_lane_m;
  logic               wr_stat_sel, wr_stat_all, wr_mask_full, wr_mask_all;
  logic               wr_mask_set, wr_mask_clr, wr_ctrl, wr_vec;
  logic [NUM_SRC-1:0] status, mask, set_evt;
  logic               enable;
  logic [VEC_W-1:0]   vec;

  attn_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_lane
    assign src_lane_m[i] = be_i[i / 8];
  end
  for (genvar i = 0; i < VEC_W; i++) begin : g_vec_lane
    assign vec_lane_m[i] = be_i[i / 8];
  end
  if (DATA_W > NUM_SRC) begin : g_unused_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];
  end

  always_comb begin
    wsrc         = wdata_i[NUM_SRC-1:0] & src_lane_m;
    wr_stat_sel  = wr_i && (addr_i == REG_STAT);
    wr_stat_all  = wr_i && (addr_i == REG_STAT_CLR_ALL);
    wr_mask_full = wr_i && (addr_i == REG_MASK);
    wr_mask_all  = wr_i && (addr_i == REG_MASK_CLR_ALL);
    wr_mask_set  = wr_i && (addr_i == REG_MASK_SET_SEL);
    wr_mask_clr  = wr_i && (addr_i == REG_MASK_CLR_SEL);
    wr_ctrl      = wr_i && (addr_i == REG_CTRL) && be_i[0];
    wr_vec       = wr_i && (addr_i == REG_VEC) && (|vec_lane_m);
  end

  attn_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_i     (src_i),
    .clr_all_i (wr_stat_all),
    .clr_sel_i (wr_stat_sel ? wsrc : '0),
    .status_o  (status),
    .set_evt_o (set_evt)
  );

  attn_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_full_i    (wr_mask_full),
    .full_wmask_i (src_lane_m),
    .full_data_i  (wdata_i[NUM_SRC-1:0]),
    .clr_all_i    (wr_mask_all),
    .set_sel_i    (wr_mask_set ? wsrc : '0),
    .clr_sel_i    (wr_mask_clr ? wsrc : '0),
    .mask_o       (mask)
  );

  attn_irq_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en_wr_i     (wr_ctrl),
    .en_data_i   (wdata_i[0]),
    .vec_wr_i    (wr_vec),
    .vec_wmask_i (vec_lane_m),
    .vec_data_i  (wdata_i[VEC_W-1:0]),
    .status_i    (status),
    .mask_i      (mask),
    .set_evt_i   (set_evt),
    .iack_i      (iack_i),
    .en_o        (enable),
    .vec_o       (vec),
    .iack_vec_o  (iack_vec_o),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        REG_STAT: rdata_o[NUM_SRC-1:0] = status;
        REG_MASK: rdata_o[NUM_SRC-1:0] = mask;
        REG_CTRL: rdata_o[0]           = enable;
        REG_VEC:  rdata_o[VEC_W-1:0]   = vec;
        default:  rdata_o              = '0;
      endcase
    end
  end

  a_r9_reset_quiet: assert property (@(posedge clk)
    (!rst_sync_n) |=> (!irq_o && status == '0 && mask == '0 && vec == '0));

  a_r9_no_read_no_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_i |-> (rdata_o == '0));

  initial begin
    a_r4_lanes_cover: assert (NUM_LANES * 8 == DATA_W && NUM_SRC <= DATA_W && VEC_W <= DATA_W);
  end
endmodule

// File: tb/attn_irq_regs_tb.sv
module attn_irq_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NTBL       = 32;
  localparam logic [3:0] K_WR = 4'd0, K_RD = 4'd1, K_SRC = 4'd2;

  // {req, kind, addr, be, data, expected read, expected irq}
  localparam logic [51:0] TBL [NTBL] = '{
    {4'd6, K_WR,  4'h6, 4'h3, 16'h0001, 16'h0000, 4'h0}, // R6 enable on
    {4'd4, K_WR,  4'h2, 4'h3, 16'h00F5, 16'h0000, 4'h0}, // R4
    {4'd4, K_RD,  4'h2, 4'h3, 16'h0000, 16'h00F5, 4'h0}, // R4
    {4'd4, K_WR,  4'h2, 4'h2, 16'h0A00, 16'h0000, 4'h0}, // R4 upper lane only
    {4'd4, K_RD,  4'h2, 4'h3, 16'h0000, 16'h0AF5, 4'h0}, // R4
    {4'd4, K_WR,  4'h2, 4'h0, 16'h0FFF, 16'h0000, 4'h0}, // R4 no lanes
    {4'd4, K_RD,  4'h2, 4'h3, 16'h0000, 16'h0AF5, 4'h0}, // R4
    {4'd1, K_SRC, 4'h0, 4'h0, 16'h0001, 16'h0000, 4'h1}, // R1 R6
    {4'd1, K_RD,  4'h0, 4'h3, 16'h0000, 16'h0001, 4'h1}, // R1
    {4'd2, K_SRC, 4'h0, 4'h0, 16'h0002, 16'h0000, 4'h1}, // R2
    {4'd3, K_WR,  4'h0, 4'h3, 16'h0001, 16'h0000, 4'h0}, // R3 selective
    {4'd3, K_RD,  4'h0, 4'h3, 16'h0000, 16'h0002, 4'h0}, // R3
    {4'd5, K_WR,  4'h4, 4'h3, 16'h0002, 16'h0000, 4'h1}, // R5 set
    {4'd5, K_RD,  4'h2, 4'h3, 16'h0000, 16'h0AF7, 4'h1}, // R5
    {4'd5, K_WR,  4'h5, 4'h3, 16'h0002, 16'h0000, 4'h0}, // R5 clear
    {4'd5, K_WR,  4'h4, 4'h3, 16'h0002, 16'h0000, 4'h1}, // R5
    {4'd6, K_WR,  4'h6, 4'h3, 16'h0000, 16'h0000, 4'h0}, // R6 enable off
    {4'd6, K_RD,  4'h6, 4'h3, 16'h0000, 16'h0000, 4'h0}, // R6
    {4'd6, K_WR,  4'h6, 4'h3, 16'h0001, 16'h0000, 4'h1}, // R6
    {4'd5, K_WR,  4'h3, 4'h3, 16'h0000, 16'h0000, 4'h0}, // R5 clear all
    {4'd5, K_RD,  4'h2, 4'h3, 16'h0000, 16'h0000, 4'h0}, // R5
    {4'd3, K_WR,  4'h1, 4'h3, 16'h0000, 16'h0000, 4'h0}, // R3 clear all
    {4'd3, K_RD,  4'h0, 4'h3, 16'h0000, 16'h0000, 4'h0}, // R3
    {4'd7, K_WR,  4'h7, 4'h3, 16'h01A5, 16'h0000, 4'h0}, // R7
    {4'd7, K_RD,  4'h7, 4'h3, 16'h0000, 16'h00A5, 4'h0}, // R7
    {4'd7, K_WR,  4'h7, 4'h2, 16'h5A00, 16'h0000, 4'h0}, // R7 wrong lane
    {4'd7, K_RD,  4'h7, 4'h3, 16'h0000, 16'h00A5, 4'h0}, // R7
    {4'd6, K_RD,  4'h6, 4'h3, 16'h0000, 16'h0001, 4'h0}, // R6
    {4'd9, K_RD,  4'hF, 4'h3, 16'h0000, 16'h0000, 4'h0}, // R9 unmapped
    {4'd6, K_SRC, 4'h0, 4'h0, 16'h0800, 16'h0000, 4'h0}, // R6 masked source
    {4'd1, K_RD,  4'h0, 4'h3, 16'h0000, 16'h0800, 4'h0}, // R1
    {4'd3, K_WR,  4'h1, 4'h3, 16'h0000, 16'h0000, 4'h0}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] src_i;
  logic [3:0]  addr_i;
  logic        wr_i, rd_i, iack_i;
  logic [15:0] wdata_i;
  logic [1:0]  be_i;
  logic [15:0] rdata_o;
  logic [7:0]  iack_vec_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attn_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i), .wr_i(wr_i),
    .rd_i(rd_i), .wdata_i(wdata_i), .be_i(be_i), .rdata_o(rdata_o),
    .iack_i(iack_i), .iack_vec_o(iack_vec_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    addr_i = a; wdata_i = d; be_i = b; wr_i = 1'b1; rd_i = 1'b0;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1; wr_i = 1'b0;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic src_pulse(input logic [11:0] s);
    @(negedge clk);
    src_i = s;
    @(negedge clk);
    src_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    rst_n = 1'b1; src_i = '0; addr_i = '0; wr_i = 1'b0; rd_i = 1'b0;
    wdata_i = '0; be_i = '0; iack_i = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 irq after reset", {15'd0, irq_o}, 16'h0000);
    for (int a = 0; a < 8; a++) begin
      bus_read(a[3:0], rd);
      chk($sformatf("R9 reset read addr %0d", a), rd, 16'h0000);
    end
    chk("R9 idle bus", rdata_o, 16'h0000);

    // table walk
    for (int k = 0; k < NTBL; k++) begin
      logic [51:0] e;
      e = TBL[k];
      case (e[47:44])
        K_WR:  bus_write(e[43:40], e[35:20], e[37:36]);
        K_SRC: src_pulse(e[31:20]);
        default: begin
          bus_read(e[43:40], rd);
          chk($sformatf("R%0d table %0d read", e[51:48], k), rd, e[19:4]);
        end
      endcase
      chk($sformatf("R%0d table %0d irq", e[51:48], k), {15'd0, irq_o}, {15'd0, e[0]});
    end

    // R2: source edge and selective clear of the same bit in one cycle
    bus_write(4'h2, 16'h0010, 2'b11);
    @(negedge clk);
    src_i = 12'h010; addr_i = 4'h0; wdata_i = 16'h0010; be_i = 2'b11; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    bus_read(4'h0, rd);
    chk("R2 set beats clear", rd, 16'h0010);
    chk("R2 irq", {15'd0, irq_o}, 16'h0001);

    // R1: held level does not set the bit again
    bus_write(4'h0, 16'h0010, 2'b11);
    repeat (2) @(negedge clk);
    bus_read(4'h0, rd);
    chk("R1 held level", rd, 16'h0000);
    chk("R1 irq after clear", {15'd0, irq_o}, 16'h0000);
    src_i = '0;

    // R8 / R7 acknowledge handshake
    src_pulse(12'h010);
    chk("R8 irq before ack", {15'd0, irq_o}, 16'h0001);
    chk("R7 vector idle", {8'd0, iack_vec_o}, 16'h0000);
    @(negedge clk);
    iack_i = 1'b1;
    #1 chk("R7 vector in ack", {8'd0, iack_vec_o}, 16'h00A5);
    @(negedge clk);
    iack_i = 1'b0;
    chk("R8 release on ack", {15'd0, irq_o}, 16'h0001 & 16'h0000);
    repeat (3) @(negedge clk);
    chk("R8 stays low", {15'd0, irq_o}, 16'h0000);
    src_pulse(12'h040);
    chk("R8 unmasked edge no rearm", {15'd0, irq_o}, 16'h0000);
    bus_read(4'h0, rd);
    chk("R8 status kept", rd, 16'h0050);
    bus_write(4'h4, 16'h0020, 2'b11);
    chk("R8 mask write no rearm", {15'd0, irq_o}, 16'h0000);
    src_pulse(12'h020);
    chk("R8 masked edge rearms", {15'd0, irq_o}, 16'h0001);

    // R9 reset again from a busy state
    do_reset();
    chk("R9 irq after second reset", {15'd0, irq_o}, 16'h0000);
    bus_read(4'h2, rd); chk("R9 mask cleared", rd, 16'h0000);
    bus_read(4'h0, rd); chk("R9 status cleared", rd, 16'h0000);
    bus_read(4'h6, rd); chk("R9 enable cleared", rd, 16'h0000);
    bus_read(4'h7, rd); chk("R9 vector cleared", rd, 16'h0000);

    finish_run();
  end
endmodule